// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block is the clocked register stage that sits on a memory module's command/address bus. On every rising clock edge it captures a set of address/command data lanes, plus three module-level control inputs: clock enable, on-die termination and chip select. It then drives the captured values onto a bank of registered output positions. Two static strap inputs pick how the captured bits are laid out on those outputs. In the wide layout every input has one output. In the narrow layout half of the data lanes, together with the controls, are fanned out to two identical copies. A side strap then chooses which half of the lanes is used and where the control bits sit.

To save power, the data lanes stop loading while both active-low select inputs are high, so the data outputs keep their last value. The three control registers keep loading, so power-down and termination control still follow the host. If the second select is tied low, the hold can never engage and the stage acts as a plain register. An asynchronous active-low reset clears every register. Reset wins over the hold.

Top module: `cab_regbuf`

## Requirements
- R1: While rst_n is low, every bit of q_out is 0. After rst_n rises, q_out stays 0 until the next rising clock edge.
- R2: With strap_fanout = 0 (wide layout), one rising edge after capture q_out[2:0] = {cs, odt, cke}, and q_out[24:3] = data lanes 21..0 in order. Here cs is sel0_n, odt is odt_in and cke is cke_in, each as sampled at that edge.
- R3: With strap_fanout = 0, q_out[27:25] are always 0.
- R4: With strap_fanout = 1 and strap_side = 0, the 14-bit word is {data lanes 10..0, cs, odt, cke}, with cke at bit 0 and data lane 0 at bit 3.
- R5: With strap_fanout = 1 and strap_side = 1, the 14-bit word is {cs, odt, cke, data lanes 21..11}, with data lane 11 at bit 0 and cke at bit 11.
- R6: With strap_fanout = 1, q_out[13:0] and q_out[27:14] carry the same word.
- R7: At a rising edge where sel0_n and sel1_n are both 1, the registered data lanes keep their previous values, so the data positions of q_out do not change.
- R8: The cs, odt and cke registers load at every rising edge, including edges where the data hold is active.
- R9: At a rising edge where sel0_n or sel1_n is 0, the data lanes load from data_in.
- R10: Pulling rst_n low during a hold clears q_out at once, without waiting for a clock edge.
- R11: With sel1_n held at 0, every edge loads the data lanes, whatever the value of sel0_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fanout | input | 1 | Static strap: 0 selects the wide layout, 1 selects the narrow two-copy layout |
| strap_side | input | 1 | Static strap: picks the lane half and control placement in the narrow layout |
| sel0_n | input | 1 | Active-low select; it is also the registered chip-select bit |
| sel1_n | input | 1 | Second active-low select, used only for the hold |
| cke_in | input | 1 | Clock-enable input |
| odt_in | input | 1 | On-die termination input |
| data_in | input | 22 | Address/command data lanes |
| q_out | output | 28 | Registered output positions |

## Verification
The bench's targets are the select combinations at the edge of the hold. A design that decoded the hold with an OR, or that looked at only one select, would freeze or update in cycles where a reference model predicts the opposite. Edges where the hold is active and the control inputs change are aimed at a design that gated the control registers with the data hold, which would show a stale cke or odt. All three layouts are run with lane patterns that differ between the two halves. A swapped half or a misplaced control field would therefore show up as a position mismatch, and a broken second copy would show up in the copy check. Reset is dropped in the middle of a hold cycle to catch a design that needs a clock edge to clear, or that lets the hold win over reset.

// File: rtl/cab_pkg.sv
package cab_pkg;

  // Control field as it is registered: cke lowest, cs highest.
  typedef struct packed {
    logic cs;
    logic odt;
    logic cke;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Output layout, decoded from the two straps.
  typedef enum logic [1:0] {
    LAYOUT_WIDE     = 2'b00,
    LAYOUT_NARROW_A = 2'b10,
    LAYOUT_NARROW_B = 2'b11
  } layout_e;

  function automatic layout_e decode_layout(input logic fanout, input logic side);
    if (!fanout) return LAYOUT_WIDE;
    return side ? LAYOUT_NARROW_B : LAYOUT_NARROW_A;
  endfunction

endpackage

// File: rtl/cab_hold_reg.sv
module cab_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end

endmodule

// File: rtl/cab_outmux.sv
module cab_outmux
  import cab_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  layout_e                         layout,
  input  logic [DATA_W-1:0]               data_q,
  input  ctrl_t                           ctrl_q,
  output logic [DATA_W+2*CTRL_W-1:0]      q_out
);

  localparam int NARROW_W = DATA_W / 2;
  localparam int HALF_W   = NARROW_W + CTRL_W;
  localparam int OUT_W    = 2 * HALF_W;
  localparam int SPARE_W  = OUT_W - DATA_W - CTRL_W;
  localparam int COPIES   = 2;

  // Wide layout: controls at the bottom, all lanes above, spare tops low.
  function automatic logic [OUT_W-1:0] wide_word(input logic [DATA_W-1:0] d, input ctrl_t c);
    return {{SPARE_W{1'b0}}, d, c};
  endfunction

  // Narrow layout: side A uses the low lanes with controls below them,
  // side B uses the high lanes with controls above them.
  function automatic logic [HALF_W-1:0] narrow_word(input logic [DATA_W-1:0] d, input ctrl_t c,
                                                   input logic side_b);
    if (!side_b) return {d[NARROW_W-1:0], c};
    return {c, d[NARROW_W +: NARROW_W]};
  endfunction

  logic [HALF_W-1:0] half_word;
  logic [OUT_W-1:0]  fan_word;

  assign half_word = narrow_word(data_q, ctrl_q, layout == LAYOUT_NARROW_B);

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    assign fan_word[k*HALF_W +: HALF_W] = half_word;
  end

  assign q_out = (layout == LAYOUT_WIDE) ? wide_word(data_q, ctrl_q) : fan_word;

endmodule

// File: rtl/cab_regbuf.sv
module cab_regbuf
  import cab_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strap_fanout,
  input  logic                        strap_side,
  input  logic                        sel0_n,
  input  logic                        sel1_n,
  input  logic                        cke_in,
  input  logic                        odt_in,
  input  logic [DATA_W-1:0]           data_in,
  output logic [DATA_W+2*CTRL_W-1:0]  q_out
);

  // Named internal events for the checker.
  logic    hold_evt;
  ctrl_t   ctrl_in;
  ctrl_t   ctrl_q;
  logic [DATA_W-1:0] data_q;
  layout_e layout;

  assign hold_evt = sel0_n & sel1_n;
  assign ctrl_in  = '{cs: sel0_n, odt: odt_in, cke: cke_in};
  assign layout   = decode_layout(strap_fanout, strap_side);

  cab_hold_reg #(.W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (~hold_evt),
    .d       (data_in),
    .q       (data_q)
  );

  cab_hold_reg #(.W(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (1'b1),
    .d       (ctrl_in),
    .q       (ctrl_q)
  );

  cab_outmux #(.DATA_W(DATA_W)) u_mux (
    .layout (layout),
    .data_q (data_q),
    .ctrl_q (ctrl_q),
    .q_out  (q_out)
  );

endmodule

// File: rtl/cab_regbuf_chk.sv
module cab_regbuf_chk #(
  parameter int DATA_W = 22,
  parameter int CTRL_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        strap_fanout,
  input logic                        hold_evt,
  input logic [DATA_W-1:0]           data_in,
  input logic [DATA_W-1:0]           data_q,
  input logic [CTRL_W-1:0]           ctrl_in,
  input logic [CTRL_W-1:0]           ctrl_q,
  input logic [DATA_W+2*CTRL_W-1:0]  q_out
);

  localparam int HALF_W = DATA_W / 2 + CTRL_W;
  localparam int OUT_W  = DATA_W + 2 * CTRL_W;

  // R1: outputs cleared during reset
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> q_out == '0);

  // R3: spare positions low in the wide layout
  a_r3_spare_low: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_fanout |-> q_out[OUT_W-1 -: CTRL_W] == '0);

  // R6: both copies agree in the narrow layout
  a_r6_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    strap_fanout |-> q_out[HALF_W-1:0] == q_out[OUT_W-1:HALF_W]);

  // R7: data lanes frozen across a hold edge
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(data_q));

  // R8: control registers load every edge
  a_r8_ctrl_loads: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ctrl_q == $past(ctrl_in));

  // R9: data lanes load when a select is active
  a_r9_data_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_evt |=> data_q == $past(data_in));

endmodule

bind cab_regbuf cab_regbuf_chk #(.DATA_W(DATA_W), .CTRL_W(cab_pkg::CTRL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strap_fanout (strap_fanout),
  .hold_evt     (hold_evt),
  .data_in      (data_in),
  .data_q       (data_q),
  .ctrl_in      (ctrl_in),
  .ctrl_q       (ctrl_q),
  .q_out        (q_out)
);

// File: tb/sim_cab_regbuf.sv
`timescale 1ns/1ps
module sim_cab_regbuf;

  localparam int DW = 22;
  localparam int OW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strap_fanout = 1'b0;
  logic          strap_side = 1'b0;
  logic          sel0_n = 1'b1;
  logic          sel1_n = 1'b1;
  logic          cke_in = 1'b0;
  logic          odt_in = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [OW-1:0] q_out;

  always #4 clk = ~clk;

  cab_regbuf u0 (
    .clk(clk), .rst_n(rst_n), .strap_fanout(strap_fanout), .strap_side(strap_side),
    .sel0_n(sel0_n), .sel1_n(sel1_n), .cke_in(cke_in), .odt_in(odt_in),
    .data_in(data_in), .q_out(q_out)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [OW-1:0] q;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  // Bench model state
  logic [DW-1:0] m_data = '0;
  logic          m_cke = 1'b0, m_odt = 1'b0, m_cs = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [OW-1:0] model_q(input logic fan, input logic side);
    logic [OW-1:0] r = '0;
    logic [13:0]   w = '0;
    if (!fan) begin
      r[0] = m_cke; r[1] = m_odt; r[2] = m_cs;
      for (int i = 0; i < DW; i++) r[3+i] = m_data[i];
    end else begin
      if (!side) begin
        w[0] = m_cke; w[1] = m_odt; w[2] = m_cs;
        for (int i = 0; i < 11; i++) w[3+i] = m_data[i];
      end else begin
        for (int i = 0; i < 11; i++) w[i] = m_data[11+i];
        w[11] = m_cke; w[12] = m_odt; w[13] = m_cs;
      end
      for (int i = 0; i < 14; i++) begin
        r[i] = w[i];
        r[14+i] = w[i];
      end
    end
    return r;
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic step(input logic [DW-1:0] d, input logic ck, input logic od,
                      input logic s0, input logic s1, input string tag);
    exp_t e;
    @(negedge clk);
    data_in = d; cke_in = ck; odt_in = od; sel0_n = s0; sel1_n = s1;
    @(posedge clk);
    if (!(s0 && s1)) m_data = d;
    m_cke = ck; m_odt = od; m_cs = s0;
    #1;
    e.q = model_q(strap_fanout, strap_side);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(q_out === e.q, e.tag, q_out, e.q);
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset(input logic fan, input logic side);
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    strap_fanout = fan; strap_side = side;
    sel0_n = 1'b1; sel1_n = 1'b1;
    m_data = '0; m_cke = 1'b0; m_odt = 1'b0; m_cs = 1'b0;
    @(negedge clk);
    check(q_out === '0, "R1 in reset", q_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(q_out === '0, "R1 after release", q_out, '0);
  endtask

  task automatic run_phase(input int n, input string tag_upd, input logic tie_sel1);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d;
      logic s0, s1;
      d  = DW'($urandom());
      s0 = 1'($urandom());
      s1 = tie_sel1 ? 1'b0 : 1'($urandom());
      if (i == 1) begin s0 = 1'b1; s1 = 1'b1 && !tie_sel1; end
      if (s0 && s1) step(d, 1'($urandom()), 1'($urandom()), s0, s1, "R7,R8 hold");
      else          step(d, 1'($urandom()), 1'($urandom()), s0, s1, tag_upd);
    end
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, wide layout
    do_reset(1'b0, 1'b0);

    // R2 / R9: wide layout, each select alone enables loading
    step(22'h3FFFFF, 1'b1, 1'b0, 1'b0, 1'b1, "R2 sel0 active");
    step(22'h155555, 1'b0, 1'b1, 1'b1, 1'b0, "R9 sel1 active");
    // R7 / R8: hold with controls changing
    step(22'h0AAAAA, 1'b1, 1'b1, 1'b1, 1'b1, "R7,R8 hold");
    step(22'h000001, 1'b0, 1'b0, 1'b1, 1'b1, "R7,R8 hold");
    step(22'h200000, 1'b1, 1'b0, 1'b0, 1'b0, "R9 both active");
    run_phase(20, "R2 wide update", 1'b0);
    drain();
    @(negedge clk);
    check(q_out[27:25] === 3'b000, "R3 spare bits", q_out, {3'b000, q_out[24:0]});

    // R10: reset asserted in the middle of a hold cycle
    step(22'h123456, 1'b1, 1'b1, 1'b0, 1'b1, "R2 preload");
    step(22'h3ABCDE, 1'b1, 1'b1, 1'b1, 1'b1, "R7,R8 hold");
    drain();
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(q_out === '0, "R10 reset over hold", q_out, '0);

    // R4 / R6: narrow layout, side A
    do_reset(1'b1, 1'b0);
    step(22'h2AA555, 1'b1, 1'b0, 1'b0, 1'b1, "R4 narrow A");
    step(22'h0007FF, 1'b0, 1'b1, 1'b1, 1'b0, "R4 narrow A");
    run_phase(16, "R4 narrow A", 1'b0);
    drain();
    @(negedge clk);
    check(q_out[13:0] === q_out[27:14], "R6 copies side A", q_out,
          {q_out[13:0], q_out[13:0]});

    // R5 / R6: narrow layout, side B
    do_reset(1'b1, 1'b1);
    step(22'h3FF800, 1'b1, 1'b1, 1'b0, 1'b0, "R5 narrow B");
    step(22'h0007FF, 1'b0, 1'b0, 1'b0, 1'b1, "R5 narrow B");
    run_phase(16, "R5 narrow B", 1'b0);
    drain();
    @(negedge clk);
    check(q_out[13:0] === q_out[27:14], "R6 copies side B", q_out,
          {q_out[13:0], q_out[13:0]});

    // R11: second select tied low, sel0_n high must still load
    do_reset(1'b0, 1'b0);
    step(22'h1F0F0F, 1'b1, 1'b0, 1'b1, 1'b0, "R11 tied select");
    step(22'h20F0F0, 1'b0, 1'b1, 1'b1, 1'b0, "R11 tied select");
    run_phase(12, "R11 tied select", 1'b1);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule